// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block sits in an instruction front end and breaks one 32-bit multiple-register load or store word into a stream of simple micro-ops. It issues one micro-op per handshake on a valid/ready pair. The first micro-op is a copy of the base register. Next comes one single-register transfer for every set bit of the 16-bit register list, lowest bit first. Each transfer carries its register index and a byte offset from the base. If the word asks for base writeback, a final base-update micro-op follows. It carries a synthesized add- or subtract-immediate instruction word.

The addressing mode lives in bits 24:20 of the word: bit 24 pre-index, bit 23 up, bit 22 S, bit 21 writeback, bit 20 load. The base register is in bits 19:16 and the register list in bits 15:0. If n is the number of set bits in the list, the first offset depends on the pre-index and up bits, and each transfer steps it by 4 in the direction of the up bit.

The sequence is run by a four-state machine:
- IDLE waits for a start strobe.
- BASE issues the base copy.
- XFER issues the transfers.
- WBACK issues the writeback micro-op.

Its transitions are:
- accept: IDLE to BASE, on a start with a legal mode.
- reject: IDLE to IDLE with an error pulse.
- to_xfer: BASE to XFER, when the list is non-empty.
- skip_xfer: BASE to WBACK or to IDLE, when the list is empty.
- next_xfer: XFER to XFER.
- xfer_done: XFER to WBACK or to IDLE.
- wb_done: WBACK to IDLE.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset the block is idle: busy, out_valid and mode_err are all 0.
- R2: A start while idle with bit 22 of the word set is rejected. mode_err is 1 for exactly the one cycle after the start, and busy and out_valid stay 0. Every mode with bit 22 clear is accepted.
- R3: The first micro-op of an accepted word has these fields: kind 0 (base copy), reg equal to bits 19:16, offset 0, and word equal to the input word with bits 15:0 cleared.
- R4: One transfer micro-op follows for each set bit of bits 15:0, in ascending bit order, with reg set to the bit index. Its kind is 1 (load) when bit 20 is set and 2 (store) otherwise.
- R5: The first transfer offset depends on the mode, with n the number of set list bits:
  - 4n-4 when pre-index=0 and up=0.
  - 0 when pre-index=0 and up=1.
  - 4n when pre-index=1 and up=0.
  - 4 when pre-index=1 and up=1.
- R6: Each later transfer offset is the previous one plus 4 when bit 23 is set, and minus 4 when it is clear.
- R7: When bit 21 is set, a final micro-op follows the transfers. Its kind is 3 (add) when bit 23 is set and 4 (subtract) otherwise, reg equals the base register, and offset is 0. Its word is {bits 31:28, 8'h24, base, base, 4'h0, 8-bit value 4n}.
- R8: uop_last is 1 on the final micro-op of the sequence and 0 on every other one.
- R9: An empty register list yields only the base copy, plus the writeback micro-op when bit 21 is set.
- R10: While out_valid is 1 and out_ready is 0, all micro-op outputs hold their values.
- R11: A start while busy is ignored and does not disturb the running sequence.
- R12: busy is 1 from the cycle after an accepted start until the handshake of the last micro-op, and 0 in the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled only while idle |
| instr | input | 32 | Multiple-transfer instruction word |
| out_ready | input | 1 | Consumer ready for a micro-op |
| out_valid | output | 1 | Micro-op outputs are valid |
| uop_kind | output | 3 | 0 base copy, 1 load, 2 store, 3 add, 4 subtract |
| uop_reg | output | 4 | Register index |
| uop_offset | output | 8 | Byte offset from the base (zero on base copy and writeback) |
| uop_word | output | 32 | Instruction word of the base-copy and writeback micro-ops |
| uop_last | output | 1 | Final micro-op of the sequence |
| busy | output | 1 | Sequence in progress |
| mode_err | output | 1 | One-cycle pulse for a rejected mode |

## Verification
The assertions check the handshake rules on every cycle:
- Outputs hold while stalled.
- out_valid never appears without busy.
- Offsets stay word aligned.
- busy falls right after the last handshake.
- Every sequence opens with a base copy.
- An error pulse never coincides with activity.

Only the bench's scenarios can show the actual content of a sequence. That covers the per-mode start offsets, the ascending register order, the step direction, the exact writeback word, the empty-list cases, and whether a start issued mid-sequence was truly ignored.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    typedef enum logic [2:0] {
        UOP_BASE  = 3'd0,
        UOP_LOAD  = 3'd1,
        UOP_STORE = 3'd2,
        UOP_ADDI  = 3'd3,
        UOP_SUBI  = 3'd4
    } uop_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BASE  = 2'd1,
        ST_XFER  = 2'd2,
        ST_WBACK = 2'd3
    } seq_state_e;

    // Addressing-mode field, most significant bit first.
    typedef struct packed {
        logic pre;
        logic up;
        logic spec;
        logic wb;
        logic ld;
    } mode_t;

endpackage

// File: rtl/bxs_mode_decode.sv
module bxs_mode_decode #(
    parameter int NREG  = 16,
    parameter int CNT_W = $clog2(NREG + 1),
    parameter int OFF_W = $clog2(4 * NREG + 1) + 1
) (
    input  logic [31:0]       instr,
    output bxs_pkg::mode_t    mode,
    output logic              legal,
    output logic [CNT_W-1:0]  cnt,
    output logic [OFF_W-1:0]  start_off
);
    logic [OFF_W-1:0] four_n;

    assign mode  = bxs_pkg::mode_t'(instr[24:20]);
    assign legal = ~mode.spec;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNT_W'(instr[i]);
        end
    end

    assign four_n = OFF_W'(cnt) << 2;

    always_comb begin
        unique case ({mode.pre, mode.up})
            2'b00:   start_off = four_n - OFF_W'(4);
            2'b01:   start_off = '0;
            2'b10:   start_off = four_n;
            default: start_off = OFF_W'(4);
        endcase
    end
endmodule

// File: rtl/bxs_mask_pick.sv
module bxs_mask_pick #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  mask,
    output logic [IDX_W-1:0] idx,
    output logic             single,
    output logic [NREG-1:0]  rest
);
    // Clear the lowest set bit.
    assign rest   = mask & (mask - NREG'(1));
    assign single = (mask != '0) && (rest == '0);

    // Lowest set bit wins: scan from the top so low bits overwrite.
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/bxs_wb_word.sv
module bxs_wb_word #(
    parameter int CNT_W = 5
) (
    input  logic [31:0]      instr,
    input  logic [CNT_W-1:0] cnt,
    output logic [31:0]      word
);
    logic [3:0] base;
    logic [7:0] imm;

    assign base = instr[19:16];
    assign imm  = 8'(cnt) << 2;
    assign word = {instr[31:28], 8'h24, base, base, 4'h0, imm};
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
    parameter int NREG = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] instr,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [2:0]  uop_kind,
    output logic [3:0]  uop_reg,
    output logic [7:0]  uop_offset,
    output logic [31:0] uop_word,
    output logic        uop_last,
    output logic        busy,
    output logic        mode_err
);
    import bxs_pkg::*;

    localparam int CNT_W = $clog2(NREG + 1);
    localparam int OFF_W = $clog2(4 * NREG + 1) + 1;
    localparam int IDX_W = $clog2(NREG);

    seq_state_e       state_q, state_d;
    logic [31:0]      instr_q;
    logic [NREG-1:0]  mask_q;
    logic [OFF_W-1:0] off_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;

    mode_t            in_mode, run_mode;
    logic             in_legal;
    logic [CNT_W-1:0] in_cnt;
    logic [OFF_W-1:0] in_off;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_single;
    logic [NREG-1:0]  pick_rest;
    logic [31:0]      wb_word;
    logic             fire, accept;

    bxs_mode_decode #(.NREG(NREG), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_dec (
        .instr     (instr),
        .mode      (in_mode),
        .legal     (in_legal),
        .cnt       (in_cnt),
        .start_off (in_off)
    );

    bxs_mask_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .mask   (mask_q),
        .idx    (pick_idx),
        .single (pick_single),
        .rest   (pick_rest)
    );

    bxs_wb_word #(.CNT_W(CNT_W)) u_wb (
        .instr (instr_q),
        .cnt   (cnt_q),
        .word  (wb_word)
    );

    assign run_mode = mode_t'(instr_q[24:20]);
    assign fire     = out_valid & out_ready;
    assign accept   = (state_q == ST_IDLE) & start & in_legal;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_BASE;
            end
            ST_BASE: begin
                if (fire) begin
                    if (mask_q != '0)     state_d = ST_XFER;
                    else if (run_mode.wb) state_d = ST_WBACK;
                    else                  state_d = ST_IDLE;
                end
            end
            ST_XFER: begin
                if (fire && pick_single) begin
                    state_d = run_mode.wb ? ST_WBACK : ST_IDLE;
                end
            end
            ST_WBACK: begin
                if (fire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Sequence datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            mask_q  <= '0;
            off_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (state_q == ST_IDLE) & start & ~in_legal;
            if (accept) begin
                instr_q <= instr;
                mask_q  <= instr[NREG-1:0];
                off_q   <= in_off;
                cnt_q   <= in_cnt;
            end else if (state_q == ST_XFER && fire) begin
                mask_q <= pick_rest;
                off_q  <= run_mode.up ? off_q + OFF_W'(4) : off_q - OFF_W'(4);
            end
        end
    end

    // Outputs
    always_comb begin
        out_valid  = 1'b0;
        uop_kind   = UOP_BASE;
        uop_reg    = instr_q[19:16];
        uop_offset = '0;
        uop_word   = '0;
        uop_last   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
            end
            ST_BASE: begin
                out_valid = 1'b1;
                uop_kind  = UOP_BASE;
                uop_word  = {instr_q[31:16], 16'h0000};
                uop_last  = (mask_q == '0) & ~run_mode.wb;
            end
            ST_XFER: begin
                out_valid  = 1'b1;
                uop_kind   = run_mode.ld ? UOP_LOAD : UOP_STORE;
                uop_reg    = 4'(pick_idx);
                uop_offset = 8'(off_q);
                uop_last   = pick_single & ~run_mode.wb;
            end
            ST_WBACK: begin
                out_valid = 1'b1;
                uop_kind  = run_mode.up ? UOP_ADDI : UOP_SUBI;
                uop_word  = wb_word;
                uop_last  = 1'b1;
            end
            default: out_valid = 1'b0;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign mode_err = err_q;

endmodule

// File: rtl/bxs_seq_chk.sv
module bxs_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] instr,
    input logic        out_ready,
    input logic        out_valid,
    input logic [2:0]  uop_kind,
    input logic [3:0]  uop_reg,
    input logic [7:0]  uop_offset,
    input logic [31:0] uop_word,
    input logic        uop_last,
    input logic        busy,
    input logic        mode_err
);
    // R10
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(uop_kind) && $stable(uop_reg)
            && $stable(uop_offset) && $stable(uop_word) && $stable(uop_last)));

    // R12
    valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R12
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && uop_last) |=> !busy);

    // R3
    base_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (out_valid && uop_kind == 3'd0));

    // R2
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!busy && !out_valid));

    // R5
    offset_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (uop_offset[1:0] == 2'b00));

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(out_valid && out_ready && uop_last)) |=> busy);
endmodule

bind blk_xfer_seq bxs_seq_chk u_chk (.*);

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [2:0]  uop_kind;
    logic [3:0]  uop_reg;
    logic [7:0]  uop_offset;
    logic [31:0] uop_word;
    logic        uop_last;
    logic        busy;
    logic        mode_err;

    int checks = 0;
    int errors = 0;

    // Expected sequence
    logic [2:0]  e_kind [0:17];
    logic [3:0]  e_reg  [0:17];
    logic [7:0]  e_off  [0:17];
    logic [31:0] e_word [0:17];
    int          e_len;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blk_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .out_ready(out_ready), .out_valid(out_valid), .uop_kind(uop_kind),
        .uop_reg(uop_reg), .uop_offset(uop_offset), .uop_word(uop_word),
        .uop_last(uop_last), .busy(busy), .mode_err(mode_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Build the expected micro-op list from the requirements.
    task automatic build_expect(input logic [31:0] ins);
        int n = $countones(ins[15:0]);
        int off;
        logic [3:0] rn = ins[19:16];
        bit pre = ins[24], up = ins[23], wb = ins[21], ld = ins[20];
        if (!pre && !up)      off = 4 * n - 4;
        else if (!pre && up)  off = 0;
        else if (pre && !up)  off = 4 * n;
        else                  off = 4;
        e_len = 0;
        e_kind[0] = 3'd0; e_reg[0] = rn; e_off[0] = 8'd0;
        e_word[0] = {ins[31:16], 16'h0};
        e_len = 1;
        for (int j = 0; j < 16; j++) begin
            if (ins[j]) begin
                e_kind[e_len] = ld ? 3'd1 : 3'd2;
                e_reg[e_len]  = 4'(j);
                e_off[e_len]  = 8'(off);
                e_word[e_len] = 32'h0;
                e_len++;
                off = up ? off + 4 : off - 4;
            end
        end
        if (wb) begin
            e_kind[e_len] = up ? 3'd3 : 3'd4;
            e_reg[e_len]  = rn;
            e_off[e_len]  = 8'd0;
            e_word[e_len] = {ins[31:28], 28'h2400000} | (32'(rn) << 16)
                            | (32'(rn) << 12) | 32'(4 * n);
            e_len++;
        end
    endtask

    // Run one word through; stall inserts ready gaps, inject fires a start mid-run.
    task automatic run_word(input logic [31:0] ins, input bit stall, input bit inject,
                            input string req);
        int idx = 0;
        int cyc = 0;
        bit held = 0;
        bit injected = 0;
        logic [2:0] h_kind; logic [3:0] h_reg; logic [7:0] h_off;
        logic [31:0] h_word; logic h_last;
        build_expect(ins);
        @(negedge clk);
        start = 1'b1; instr = ins; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0; instr = 32'hDEAD_BEEF;
        while (idx < e_len && cyc < 200) begin
            if (inject && idx == 1 && !injected) begin
                start = 1'b1; instr = 32'hE8B0_FFFF; injected = 1;
            end else begin
                start = 1'b0;
            end
            out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            #1;
            if (held) begin
                check(out_valid && uop_kind == h_kind && uop_reg == h_reg &&
                      uop_offset == h_off && uop_word == h_word && uop_last == h_last,
                      "R10", "hold while stalled",
                      {uop_kind, uop_reg, uop_offset, 17'(uop_last)},
                      {h_kind, h_reg, h_off, 17'(h_last)});
                held = 0;
            end
            if (out_valid && !out_ready) begin
                held = 1;
                h_kind = uop_kind; h_reg = uop_reg; h_off = uop_offset;
                h_word = uop_word; h_last = uop_last;
            end
            if (out_valid && out_ready) begin
                check(uop_kind == e_kind[idx], req, $sformatf("uop %0d kind", idx),
                      32'(uop_kind), 32'(e_kind[idx]));
                check(uop_reg == e_reg[idx], req, $sformatf("uop %0d reg", idx),
                      32'(uop_reg), 32'(e_reg[idx]));
                check(uop_offset == e_off[idx], req, $sformatf("uop %0d offset", idx),
                      32'(uop_offset), 32'(e_off[idx]));
                if (idx == 0 || idx == e_len - 1 && ins[21])
                    check(uop_word == e_word[idx], req, $sformatf("uop %0d word", idx),
                          uop_word, e_word[idx]);
                check(uop_last == (idx == e_len - 1), "R8", $sformatf("uop %0d last", idx),
                      32'(uop_last), 32'(idx == e_len - 1));
                idx++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc < 200, req, "sequence completed", 32'(idx), 32'(e_len));
        #1;
        check(!busy && !out_valid, "R12", "idle after last handshake", 32'(busy), 32'h0);
        @(negedge clk); #1;
        check(!busy, "R11", "no sequence from ignored start", 32'(busy), 32'h0);
    endtask

    task automatic test_reset();
        #1;
        check(!busy && !out_valid && !mode_err, "R1", "reset state",
              {29'h0, busy, out_valid, mode_err}, 32'h0);
    endtask

    task automatic test_illegal(input logic [31:0] ins);
        @(negedge clk);
        start = 1'b1; instr = ins;
        @(negedge clk);
        start = 1'b0; #1;
        check(mode_err == 1'b1, "R2", "error pulse", 32'(mode_err), 32'h1);
        check(!busy && !out_valid, "R2", "no sequence", 32'(busy), 32'h0);
        @(negedge clk); #1;
        check(mode_err == 1'b0, "R2", "pulse one cycle", 32'(mode_err), 32'h0);
        check(!busy, "R2", "still idle", 32'(busy), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        // R4 R5 R7: increment-after load with writeback
        run_word(32'hE8B3_8421, 1'b0, 1'b0, "R5");
        // R6 R7: decrement-before store with writeback, stalled
        run_word(32'hE925_0F0F, 1'b1, 1'b0, "R6");
        // R5: decrement-after load, no writeback
        run_word(32'hE811_0006, 1'b0, 1'b0, "R5");
        // R4 R11: increment-before store, all registers, start injected
        run_word(32'hE987_FFFF, 1'b1, 1'b1, "R4");
        // R9: empty list with writeback (subtract)
        run_word(32'hE92A_0000, 1'b0, 1'b0, "R9");
        // R9: empty list without writeback
        run_word(32'hE880_0000, 1'b0, 1'b0, "R9");
        // R7: single register, add writeback
        run_word(32'hE8A2_8000, 1'b1, 1'b0, "R7");
        // R3: base copy word with non-zero condition and base
        run_word(32'h1894_0300, 1'b0, 1'b0, "R3");
        // R2: S bit set
        test_illegal(32'hE8C1_00FF);
        test_illegal(32'hE9F0_0001);
        // R2: accepted again afterwards
        run_word(32'hE831_0081, 1'b0, 1'b0, "R2");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule